// File: doc/BRIEF.md
# Timer Compare Match Unit

A free-running 16-bit counter advances on each qualified tick while it is enabled. A 16-bit compare value is checked against it on every clock. When the two first become equal after the counter moves, a match event fires. A 4-bit mode field then picks what the event does. It can drive an output latch high, drive it low or invert it. It can raise only an interrupt flag. Or it can fire a trigger, which starts an external converter and reloads the counter to zero.

In trigger mode the counter is not cleared at once. The trigger pulse appears in the cycle the match is seen, and the counter goes to zero only on the next tick. The compare value therefore works as a period register. If software rewrites the compare value so that the match no longer holds before that tick, the pending reload is dropped. A reload from a trigger never sets the overflow flag. Only a real wrap from all ones to zero does that.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset the counter, output latch, pin output, pin enable, interrupt flag, overflow flag and converter start are all zero.
- R2: The counter advances by one on each clock where `tick` is high and the run bit is 1. It holds when `tick` is low or the run bit is 0.
- R3: On a tick, the counter wraps from 0xFFFF to 0x0000 and sets `ovf_flag`. `ovf_clr` clears `ovf_flag`, and a set in the same cycle wins.
- R4: A match event fires in the first cycle where the counter equals the compare value after a tick or a compare write. In modes 0010, 1000, 1001, 1010 and 1011 it sets `irq_flag` at the next edge. `irq_clr` clears the flag, and a set in the same cycle wins.
- R5: On a match event, mode 1000 sets the latch, 1001 clears it and 0010 inverts it. In these three modes `pin_oe` is 1 and `pin_out` shows the latch.
- R6: In mode 1010 a match only sets `irq_flag`. `pin_oe` and `pin_out` stay 0.
- R7: In mode 1011, `conv_start` is high for exactly the cycle of the match event when `conv_en` is 1, and stays low when `conv_en` is 0. `pin_oe` stays 0.
- R8: In mode 1011 the counter loads 0 on the first tick after the match instead of incrementing. With compare value C, the match recurs every C+1 ticks.
- R9: A counter reload caused by the trigger never sets `ovf_flag`, including when the compare value is 0xFFFF.
- R10: If the compare value is rewritten after a trigger match so that the match no longer holds, the next tick increments the counter instead of reloading it.
- R11: While the counter stays equal to the compare value without a tick, no further event occurs. There is no repeated inversion and no new interrupt after a clear.
- R12: Writing mode 0000 forces the latch to 0. Mode codes other than the six listed behave as off: no interrupt, `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value write data |
| mode_we | input | 1 | Mode field write strobe |
| mode_wdata | input | 4 | Mode field write data |
| run_we | input | 1 | Run bit write strobe |
| run_wdata | input | 1 | Run bit write data |
| tick | input | 1 | Counter tick enable |
| conv_en | input | 1 | Converter enabled; gates the converter start |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| timer_q | output | 16 | Current counter value |
| pin_out | output | 1 | Compare output pin value |
| pin_oe | output | 1 | Compare output pin enable |
| irq_flag | output | 1 | Match interrupt flag |
| ovf_flag | output | 1 | Counter overflow flag |
| conv_start | output | 1 | Converter start pulse |

## Verification
The hardest case is a trigger match at 0xFFFF. The reload to zero there must look like a wrap to the counter but must not set the overflow flag. To reach it, the stimulus moves the compare value to all ones and ticks the counter through about sixty-five thousand steps. It then checks the trigger pulse and the reload. A second full pass in off mode checks the genuine wrap, which does set the flag. The cancelled reload needs a compare write placed between the match cycle and the next tick, and the bench keeps the tick low over exactly that window.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOGGLE  = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET     = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLEAR   = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_IRQ     = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_TRIGGER = 4'b1011;

  // Modes in which the block owns the output pin
  function automatic logic is_pin_mode(logic [MODE_W-1:0] m);
    return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLEAR);
  endfunction

  // Modes in which a match raises the interrupt flag
  function automatic logic is_irq_mode(logic [MODE_W-1:0] m);
    return is_pin_mode(m) || (m == MODE_IRQ) || (m == MODE_TRIGGER);
  endfunction

  // Next latch level for a match in mode m
  function automatic logic latch_next(logic [MODE_W-1:0] m, logic cur);
    case (m)
      MODE_SET:    return 1'b1;
      MODE_CLEAR:  return 1'b0;
      MODE_TOGGLE: return ~cur;
      default:     return cur;
    endcase
  endfunction
endpackage

// File: rtl/ctu_timer.sv
module ctu_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic         ovf_clr,
  output logic [W-1:0] count_q,
  output logic         ovf_q
);
  // {carry, sum} of one increment
  function automatic logic [W:0] step_count(logic [W-1:0] c);
    return {1'b0, c} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W:0] nxt;
  logic       wrap_set;

  assign nxt      = step_count(count_q);
  assign wrap_set = adv & ~clr & nxt[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (clr)      count_q <= '0;
      else if (adv) count_q <= nxt[W-1:0];
      if (wrap_set)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ctu_match.sv
module ctu_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic [W-1:0] cmp,
  input  logic         cmp_we,
  input  logic         adv,
  input  logic         trig_mode,
  output logic         match_now,
  output logic         match_evt,
  output logic         timer_clr
);
  logic armed_q;
  logic pend_q;

  assign match_now = (count == cmp);
  assign match_evt = match_now & armed_q;
  // Reload on the tick that ends a trigger match, only while equality holds
  assign timer_clr = adv & match_now & (pend_q | (match_evt & trig_mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (adv | cmp_we)   armed_q <= 1'b1;
      else if (match_evt) armed_q <= 1'b0;
      if (adv | ~match_now)                pend_q <= 1'b0;
      else if (match_evt & trig_mode)      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ctu_action.sv
module ctu_action
  import ctu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              match_evt,
  input  logic              conv_en,
  input  logic              irq_clr,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              conv_start
);
  logic latch_q;
  logic force_low;

  assign force_low  = mode_we & (mode_wdata == MODE_OFF);
  assign pin_oe     = is_pin_mode(mode);
  assign pin_out    = pin_oe & latch_q;
  assign conv_start = match_evt & (mode == MODE_TRIGGER) & conv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (force_low)      latch_q <= 1'b0;
      else if (match_evt) latch_q <= latch_next(mode, latch_q);
      if (match_evt && is_irq_mode(mode)) irq_flag <= 1'b1;
      else if (irq_clr)                   irq_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import ctu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic [W-1:0]      cmp_wdata,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              run_we,
  input  logic              run_wdata,
  input  logic              tick,
  input  logic              conv_en,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [W-1:0]      timer_q,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq_flag,
  output logic              ovf_flag,
  output logic              conv_start
);
  logic [W-1:0]      cmp_q;
  logic [MODE_W-1:0] mode_q;
  logic              run_q;
  logic              tick_adv;
  logic              match_now;
  logic              match_evt;
  logic              timer_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= MODE_OFF;
      run_q  <= 1'b0;
    end else begin
      if (cmp_we)  cmp_q  <= cmp_wdata;
      if (mode_we) mode_q <= mode_wdata;
      if (run_we)  run_q  <= run_wdata;
    end
  end

  assign tick_adv = run_q & tick;

  ctu_timer #(.W(W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (tick_adv),
    .clr     (timer_clr),
    .ovf_clr (ovf_clr),
    .count_q (timer_q),
    .ovf_q   (ovf_flag)
  );

  ctu_match #(.W(W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (timer_q),
    .cmp       (cmp_q),
    .cmp_we    (cmp_we),
    .adv       (tick_adv),
    .trig_mode (mode_q == MODE_TRIGGER),
    .match_now (match_now),
    .match_evt (match_evt),
    .timer_clr (timer_clr)
  );

  ctu_action u_action (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .match_evt  (match_evt),
    .conv_en    (conv_en),
    .irq_clr    (irq_clr),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq_flag   (irq_flag),
    .conv_start (conv_start)
  );
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] timer_q,
  input logic [3:0]   mode_q,
  input logic         mode_we,
  input logic [3:0]   mode_wdata,
  input logic         tick_adv,
  input logic         match_evt,
  input logic         timer_clr,
  input logic         pin_out,
  input logic         pin_oe,
  input logic         irq_flag,
  input logic         ovf_flag,
  input logic         conv_start
);
  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_adv && timer_q == {W{1'b1}} && !timer_clr) |=> ovf_flag); // R3

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && (mode_q == 4'b0010 || mode_q == 4'b1000 || mode_q == 4'b1001 ||
                   mode_q == 4'b1010 || mode_q == 4'b1011)) |=> irq_flag); // R4

  AST_NO_PIN_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 4'b1010 || mode_q == 4'b1011) |-> (!pin_oe && !pin_out)); // R6

  AST_CONV_ON_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (match_evt && mode_q == 4'b1011)); // R7

  AST_RELOAD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> (timer_q == '0 && !$rose(ovf_flag))); // R9

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !tick_adv) |=> !match_evt); // R11

  AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata == 4'b0000) |=> (!pin_out && !pin_oe)); // R12
endmodule

bind cmp_timer_unit ctu_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .timer_q    (timer_q),
  .mode_q     (mode_q),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .tick_adv   (tick_adv),
  .match_evt  (match_evt),
  .timer_clr  (timer_clr),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .irq_flag   (irq_flag),
  .ovf_flag   (ovf_flag),
  .conv_start (conv_start)
);

// File: tb/cmp_timer_unit_tb.sv
module cmp_timer_unit_tb;
  localparam int SIG_TMR = 0, SIG_OUT = 1, SIG_OE = 2, SIG_IRQ = 3, SIG_OVF = 4, SIG_CONV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_we = 0, mode_we = 0, run_we = 0, run_wdata = 0;
  logic [15:0] cmp_wdata = '0;
  logic [3:0]  mode_wdata = '0;
  logic        tick = 0, conv_en = 0, irq_clr = 0, ovf_clr = 0;
  logic [15:0] timer_q;
  logic        pin_out, pin_oe, irq_flag, ovf_flag, conv_start;

  typedef struct {
    string       req;
    int          sig;
    logic [15:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done = 0;

  always #5 clk = ~clk;

  cmp_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .run_we(run_we), .run_wdata(run_wdata),
    .tick(tick), .conv_en(conv_en), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .timer_q(timer_q), .pin_out(pin_out), .pin_oe(pin_oe), .irq_flag(irq_flag),
    .ovf_flag(ovf_flag), .conv_start(conv_start)
  );

  function automatic logic [15:0] observe(int sig);
    case (sig)
      SIG_TMR: return timer_q;
      SIG_OUT: return {15'b0, pin_out};
      SIG_OE:  return {15'b0, pin_oe};
      SIG_IRQ: return {15'b0, irq_flag};
      SIG_OVF: return {15'b0, ovf_flag};
      default: return {15'b0, conv_start};
    endcase
  endfunction

  // Monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = observe(it.sig);
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s sig%0d actual=%h expected=%h", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  task automatic expect_sig(string req, int sig, logic [15:0] v);
    sb_q.push_back('{req, sig, v});
  endtask

  // One clock: inputs set before this are sampled at the edge, strobes drop after
  task automatic cyc();
    @(posedge clk); #2;
    cmp_we = 0; mode_we = 0; run_we = 0; tick = 0; irq_clr = 0; ovf_clr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
  endtask

  task automatic wcmp(logic [15:0] v);
    cmp_we = 1; cmp_wdata = v; cyc();
  endtask

  task automatic wmode(logic [3:0] m);
    mode_we = 1; mode_wdata = m; cyc();
  endtask

  task automatic wrun(logic r);
    run_we = 1; run_wdata = r; cyc();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1; cyc();
    // R1 reset state
    expect_sig("R1", SIG_TMR, 0);  expect_sig("R1", SIG_OUT, 0); expect_sig("R1", SIG_OE, 0);
    expect_sig("R1", SIG_IRQ, 0);  expect_sig("R1", SIG_OVF, 0); expect_sig("R1", SIG_CONV, 0);

    wrun(1);
    wcmp(16'd5); wmode(4'b0010);
    ticks(3);  expect_sig("R2", SIG_TMR, 3);
    idle(2);   expect_sig("R2", SIG_TMR, 3);
    wrun(0); ticks(2); expect_sig("R2", SIG_TMR, 3);
    wrun(1);
    ticks(2);  expect_sig("R2", SIG_TMR, 5);
    cyc();     // toggle and irq land at this edge
    expect_sig("R5", SIG_OUT, 1); expect_sig("R5", SIG_OE, 1); expect_sig("R4", SIG_IRQ, 1);
    idle(3);   expect_sig("R11", SIG_OUT, 1);
    irq_clr = 1; cyc(); expect_sig("R4", SIG_IRQ, 0);
    idle(2);   expect_sig("R11", SIG_IRQ, 0);

    wcmp(16'd7); wmode(4'b1001); ticks(2); cyc();
    expect_sig("R5", SIG_OUT, 0); expect_sig("R5", SIG_OE, 1);
    wcmp(16'd9); wmode(4'b1000); ticks(2); cyc();
    expect_sig("R5", SIG_OUT, 1);

    wmode(4'b0000); expect_sig("R12", SIG_OUT, 0); expect_sig("R12", SIG_OE, 0);
    wmode(4'b1000); expect_sig("R12", SIG_OUT, 0); // latch was forced low
    irq_clr = 1; cyc(); expect_sig("R4", SIG_IRQ, 0);
    wmode(4'b0110); wcmp(16'd11); ticks(2); cyc();
    expect_sig("R12", SIG_TMR, 11); expect_sig("R12", SIG_IRQ, 0); expect_sig("R12", SIG_OE, 0);

    wmode(4'b1010); wcmp(16'd13); ticks(2); cyc();
    expect_sig("R6", SIG_IRQ, 1); expect_sig("R6", SIG_OE, 0); expect_sig("R6", SIG_OUT, 0);

    conv_en = 1;
    wmode(4'b1011); wcmp(16'd16); ticks(3);
    expect_sig("R7", SIG_TMR, 16); expect_sig("R7", SIG_CONV, 1); expect_sig("R7", SIG_OE, 0);
    cyc(); expect_sig("R7", SIG_CONV, 0); expect_sig("R8", SIG_TMR, 16);
    ticks(1); expect_sig("R8", SIG_TMR, 0); expect_sig("R9", SIG_OVF, 0);
    ticks(16); expect_sig("R8", SIG_TMR, 16); expect_sig("R8", SIG_CONV, 1);
    ticks(1); expect_sig("R8", SIG_TMR, 0);

    conv_en = 0;
    irq_clr = 1; cyc();
    ticks(16); expect_sig("R7", SIG_CONV, 0);
    cyc(); expect_sig("R4", SIG_IRQ, 1);
    ticks(1); expect_sig("R8", SIG_TMR, 0);

    ticks(16); expect_sig("R10", SIG_TMR, 16);
    wcmp(16'd20);
    ticks(1); expect_sig("R10", SIG_TMR, 17);

    conv_en = 1;
    wcmp(16'hFFFF);
    ticks(65518); expect_sig("R9", SIG_TMR, 16'hFFFF); expect_sig("R9", SIG_CONV, 1);
    ticks(1); expect_sig("R9", SIG_TMR, 0); expect_sig("R9", SIG_OVF, 0);

    wmode(4'b0000);
    ticks(65535); expect_sig("R3", SIG_TMR, 16'hFFFF); expect_sig("R3", SIG_OVF, 0);
    ticks(1); expect_sig("R3", SIG_TMR, 0); expect_sig("R3", SIG_OVF, 1);
    ovf_clr = 1; cyc(); expect_sig("R3", SIG_OVF, 0);

    idle(2);
    done = 1;
    finish_run();
  end
endmodule